// File: doc/BRIEF.md
# Video Display Processor CPU Port Controller

This block is the processor-facing side of a tile-based video display processor. The CPU reaches it through three one-byte ports: a data port, a control port and a scan-line port. Two successive writes to the control port form a 16-bit command. The top two bits of the command pick one of four operations: video RAM read, video RAM write, internal register write or color RAM write. The lower bits load an auto-incrementing video RAM address. Data-port accesses then move bytes to or from video RAM or color RAM through single-cycle strobes. The memory arrays are outside the block.

Video RAM reads come from a read-ahead buffer. Setting up a read, or reading the data port, starts a fetch of the byte at the current address into the buffer. The next data-port read therefore returns at once. The block also counts scan lines from a one-pulse-per-line tick. It raises a frame interrupt when the active display ends, and a line interrupt each time a programmable down-counter underflows during active lines. The CPU can read the current line number, and can read and clear the interrupt flags through the status port.

The access sequencer is one state machine. Its states are `ST_IDLE` (waiting for a port access), `ST_VRD` (fetch strobe issued), `ST_VCAP` (fetched byte captured into the buffer), `ST_VWR` (video RAM write strobe), `ST_CWR` (color RAM write strobe) and `ST_RWR` (register write strobe). The transitions, all taken from `ST_IDLE`, are:
- a data read, or a completed command with code 00, goes to `ST_VRD`, then `ST_VCAP`, then back to `ST_IDLE`;
- a data write goes to `ST_VWR`, or to `ST_CWR` when the current code is 11, then back to `ST_IDLE`;
- a completed command with code 10 goes to `ST_RWR`, then back to `ST_IDLE`;
- a first control byte, a status read, a scan-line read, or a completed command with code 01 or 11 stays in `ST_IDLE`.

Top module: `vdp_cpu_port`

## Requirements
- R1: After reset, `cpu_rdata` is 0, `irq` is 0, `scan_line` is 0, all four memory strobes are low, and the byte-pair toggle is clear.
- R2: A control-port write (`cpu_port`=1) with the toggle clear only stores the byte as the command low half and sets the toggle, with no strobe. A control-port write with the toggle set completes the command: command bits [15:14] come from data bits [7:6] of this byte, and command bits [13:0] become the video RAM address.
- R3: A data-port write (`cpu_port`=0) while the current code is 00, 01 or 10 drives `vram_we` high for the next cycle, with `vram_addr` set to the current address and `vram_wdata` set to the written byte. The address then increments by one, modulo 2^14.
- R4: A completed command with code 00, and every data-port read, drive `vram_re` for one cycle with the current address and then increment the address. The fetched byte (`vram_rdata` is valid one cycle after `vram_re`) is loaded into the read-ahead buffer. A data-port read returns the buffer contents as they were before that read.
- R5: A completed command with code 10 drives `reg_we` for one cycle. `reg_idx` is command bits [11:8] and `reg_val` is the low command byte. A write to register 10 sets the line-counter reload value.
- R6: A data-port write while the current code is 11 drives `cram_we` instead of `vram_we`. `cram_addr` is the low 5 address bits and `cram_wdata` is the byte. The address then increments.
- R7: A data-port access of either direction, or a status read, clears the byte-pair toggle. The next control write is then taken as a first byte.
- R8: The frame flag is set by the line tick that advances `scan_line` from ACTIVE_LINES-1 (191) to ACTIVE_LINES. `irq` is the OR of the frame flag and the line flag.
- R9: A status read (`cpu_port`=1, read) returns `{frame_flag, line_flag, 6'b0}` on `cpu_rdata` in the cycle after the access, and clears both flags and so `irq`.
- R10: On each line tick during an active line (scan_line < 192), the line counter decrements. If the counter was already 0, it reloads and sets the line flag instead. On each tick outside the active lines, it reloads. After reset the counter and its reload value are 255.
- R11: `scan_line` counts line ticks from 0 to TOTAL_LINES-1 (261) and then wraps to 0. A scan-line port read (`cpu_port`=2) returns its low 8 bits on `cpu_rdata` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | 1 | One-cycle CPU port access strobe |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_port | input | 2 | 0 data, 1 control/status, 2 scan line |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | Registered read result |
| irq | output | 1 | Pending frame or line interrupt |
| line_tick | input | 1 | One pulse per scan line from video timing |
| scan_line | output | 9 | Current scan line |
| vram_re | output | 1 | Video RAM read strobe |
| vram_we | output | 1 | Video RAM write strobe |
| vram_addr | output | 14 | Video RAM address |
| vram_wdata | output | 8 | Video RAM write byte |
| vram_rdata | input | 8 | Video RAM read byte, valid one cycle after vram_re |
| cram_we | output | 1 | Color RAM write strobe |
| cram_addr | output | 5 | Color RAM address |
| cram_wdata | output | 8 | Color RAM write byte |
| reg_we | output | 1 | Register write strobe |
| reg_idx | output | 4 | Register index |
| reg_val | output | 8 | Register value |

## Verification
The assertions assume that a CPU access arrives only while the sequencer is in `ST_IDLE`. In practice this means at least three clock cycles between accesses, so a fetch has always finished before the next data read. They also assume that `line_tick` does not fall in the same cycle as a register write or a status read. The stimulus runs from a single thread: each access is followed by four idle cycles, and line ticks are issued in their own stretch, one every four cycles, never during a CPU access.

// File: rtl/vdp_port_pkg.sv
package vdp_port_pkg;

    typedef enum logic [1:0] {
        OP_VRD  = 2'b00,
        OP_VWR  = 2'b01,
        OP_REG  = 2'b10,
        OP_CRAM = 2'b11
    } op_code_t;

    typedef enum logic [1:0] {
        PORT_DATA = 2'd0,
        PORT_CTRL = 2'd1,
        PORT_VCNT = 2'd2,
        PORT_NONE = 2'd3
    } port_sel_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_VRD,
        ST_VCAP,
        ST_VWR,
        ST_CWR,
        ST_RWR
    } acc_state_t;

endpackage

// File: rtl/vdp_cmd_fsm.sv
module vdp_cmd_fsm
    import vdp_port_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int REG_IDX_W = 4,
    parameter int CRAM_AW   = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_valid,
    input  logic                 acc_wr,
    input  logic [1:0]           acc_port,
    input  logic [7:0]           acc_wdata,
    input  logic [7:0]           vram_rdata,
    output logic                 vram_re,
    output logic                 vram_we,
    output logic [ADDR_W-1:0]    vram_addr,
    output logic [7:0]           vram_wdata,
    output logic                 cram_we,
    output logic [CRAM_AW-1:0]   cram_addr,
    output logic [7:0]           cram_wdata,
    output logic                 reg_we,
    output logic [REG_IDX_W-1:0] reg_idx,
    output logic [7:0]           reg_val,
    output logic [7:0]           rd_buf
);

    localparam int HI_W = ADDR_W - 8;

    acc_state_t             state_q, state_d;
    op_code_t               code_q;
    logic                   tog_q;
    logic [7:0]             lo_q;
    logic [ADDR_W-1:0]      addr_q;
    logic [ADDR_W-1:0]      op_addr_q;
    logic [7:0]             op_data_q;
    logic [REG_IDX_W-1:0]   op_idx_q;
    logic [7:0]             buf_q;

    logic                   is_data_wr, is_data_rd, is_ctrl_wr, is_stat_rd;
    logic [ADDR_W-1:0]      new_addr;
    op_code_t               new_code;

    assign is_data_wr = acc_valid &&  acc_wr && (acc_port == PORT_DATA);
    assign is_data_rd = acc_valid && !acc_wr && (acc_port == PORT_DATA);
    assign is_ctrl_wr = acc_valid &&  acc_wr && (acc_port == PORT_CTRL);
    assign is_stat_rd = acc_valid && !acc_wr && (acc_port == PORT_CTRL);
    assign new_addr   = {acc_wdata[HI_W-1:0], lo_q};
    assign new_code   = op_code_t'(acc_wdata[7:6]);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (state_q == ST_IDLE) begin
                    if (is_data_rd) begin
                        state_d = ST_VRD;
                    end else if (is_data_wr) begin
                        state_d = (code_q == OP_CRAM) ? ST_CWR : ST_VWR;
                    end else if (is_ctrl_wr && tog_q) begin
                        if (new_code == OP_VRD)      state_d = ST_VRD;
                        else if (new_code == OP_REG) state_d = ST_RWR;
                    end
                end
            end
            ST_VRD:  state_d = ST_VCAP;
            ST_VCAP: state_d = ST_IDLE;
            ST_VWR:  state_d = ST_IDLE;
            ST_CWR:  state_d = ST_IDLE;
            ST_RWR:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // command assembly, address and operand registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q    <= OP_VRD;
            tog_q     <= 1'b0;
            lo_q      <= '0;
            addr_q    <= '0;
            op_addr_q <= '0;
            op_data_q <= '0;
            op_idx_q  <= '0;
        end else if (state_q == ST_IDLE) begin
            if (is_data_rd || is_data_wr) begin
                tog_q     <= 1'b0;
                op_addr_q <= addr_q;
                addr_q    <= addr_q + 1'b1;
                if (is_data_wr) op_data_q <= acc_wdata;
            end else if (is_stat_rd) begin
                tog_q <= 1'b0;
            end else if (is_ctrl_wr) begin
                if (!tog_q) begin
                    lo_q  <= acc_wdata;
                    tog_q <= 1'b1;
                end else begin
                    tog_q     <= 1'b0;
                    code_q    <= new_code;
                    op_addr_q <= new_addr;
                    op_data_q <= lo_q;
                    op_idx_q  <= acc_wdata[REG_IDX_W-1:0];
                    addr_q    <= (new_code == OP_VRD) ? new_addr + 1'b1 : new_addr;
                end
            end
        end
    end

    // read-ahead buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 buf_q <= '0;
        else if (state_q == ST_VCAP) buf_q <= vram_rdata;
    end

    // outputs decoded from state
    always_comb begin
        vram_re = 1'b0;
        vram_we = 1'b0;
        cram_we = 1'b0;
        reg_we  = 1'b0;
        unique case (state_q)
            ST_VRD:  vram_re = 1'b1;
            ST_VWR:  vram_we = 1'b1;
            ST_CWR:  cram_we = 1'b1;
            ST_RWR:  reg_we  = 1'b1;
            default: ;
        endcase
    end

    assign vram_addr  = op_addr_q;
    assign vram_wdata = op_data_q;
    assign cram_addr  = op_addr_q[CRAM_AW-1:0];
    assign cram_wdata = op_data_q;
    assign reg_idx    = op_idx_q;
    assign reg_val    = op_data_q;
    assign rd_buf     = buf_q;

    AST_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (is_data_wr && state_q == ST_IDLE && code_q != OP_CRAM)
        |=> (vram_we && vram_wdata == $past(acc_wdata) && vram_addr == $past(addr_q))); // R3

    AST_READ_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (is_data_rd && state_q == ST_IDLE)
        |=> (vram_re && vram_addr == $past(addr_q))); // R4

    AST_REG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ctrl_wr && tog_q && state_q == ST_IDLE && acc_wdata[7:6] == 2'b10)
        |=> (reg_we && reg_val == $past(lo_q))); // R5

    AST_CRAM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (is_data_wr && state_q == ST_IDLE && code_q == OP_CRAM)
        |=> (cram_we && !vram_we && cram_wdata == $past(acc_wdata))); // R6

    AST_FIRST_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ctrl_wr && !tog_q && state_q == ST_IDLE)
        |=> !(vram_re || vram_we || cram_we || reg_we)); // R2

endmodule

// File: rtl/vdp_line_timer.sv
module vdp_line_timer #(
    parameter int ACTIVE_LINES = 192,
    parameter int TOTAL_LINES  = 262,
    parameter int CNT_W        = 8,
    parameter int LINE_W       = $clog2(TOTAL_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_tick,
    input  logic              flag_clr,
    input  logic [CNT_W-1:0]  reload,
    output logic [LINE_W-1:0] line_num,
    output logic              frame_flag,
    output logic              line_flag
);

    localparam logic [LINE_W-1:0] ACT_L  = LINE_W'(ACTIVE_LINES);
    localparam logic [LINE_W-1:0] LAST_L = LINE_W'(TOTAL_LINES - 1);
    localparam logic [LINE_W-1:0] EDGE_L = LINE_W'(ACTIVE_LINES - 1);

    logic [LINE_W-1:0] line_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              ff_q, lf_q;
    logic              in_active;

    assign in_active = (line_q < ACT_L);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
            cnt_q  <= '1;
            ff_q   <= 1'b0;
            lf_q   <= 1'b0;
        end else begin
            if (flag_clr) begin
                ff_q <= 1'b0;
                lf_q <= 1'b0;
            end
            if (line_tick) begin
                line_q <= (line_q == LAST_L) ? '0 : line_q + 1'b1;
                if (in_active) begin
                    if (cnt_q == '0) begin
                        cnt_q <= reload;
                        lf_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end else begin
                    cnt_q <= reload;
                end
                if (line_q == EDGE_L) ff_q <= 1'b1;
            end
        end
    end

    assign line_num   = line_q;
    assign frame_flag = ff_q;
    assign line_flag  = lf_q;

    AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (line_tick && line_num == LAST_L) |=> (line_num == '0)); // R11

    AST_FRAME_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (line_tick && line_num == EDGE_L) |=> frame_flag); // R8

    AST_BLANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (line_tick && !in_active && !line_flag) |=> !line_flag); // R10

endmodule

// File: rtl/vdp_cpu_port.sv
module vdp_cpu_port
    import vdp_port_pkg::*;
#(
    parameter int ADDR_W       = 14,
    parameter int REG_IDX_W    = 4,
    parameter int CRAM_AW      = 5,
    parameter int ACTIVE_LINES = 192,
    parameter int TOTAL_LINES  = 262,
    parameter int LINE_REG_IDX = 10,
    parameter int LINE_W       = $clog2(TOTAL_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cpu_sel,
    input  logic                 cpu_wr,
    input  logic [1:0]           cpu_port,
    input  logic [7:0]           cpu_wdata,
    output logic [7:0]           cpu_rdata,
    output logic                 irq,
    input  logic                 line_tick,
    output logic [LINE_W-1:0]    scan_line,
    output logic                 vram_re,
    output logic                 vram_we,
    output logic [ADDR_W-1:0]    vram_addr,
    output logic [7:0]           vram_wdata,
    input  logic [7:0]           vram_rdata,
    output logic                 cram_we,
    output logic [CRAM_AW-1:0]   cram_addr,
    output logic [7:0]           cram_wdata,
    output logic                 reg_we,
    output logic [REG_IDX_W-1:0] reg_idx,
    output logic [7:0]           reg_val
);

    localparam logic [REG_IDX_W-1:0] LINE_REG_L = REG_IDX_W'(LINE_REG_IDX);

    logic [7:0]        rd_buf;
    logic [7:0]        reload_q;
    logic [7:0]        rdata_q;
    logic              frame_flag, line_flag;
    logic              stat_rd;

    assign stat_rd = cpu_sel && !cpu_wr && (cpu_port == PORT_CTRL);

    vdp_cmd_fsm #(
        .ADDR_W(ADDR_W), .REG_IDX_W(REG_IDX_W), .CRAM_AW(CRAM_AW)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(cpu_sel), .acc_wr(cpu_wr), .acc_port(cpu_port),
        .acc_wdata(cpu_wdata), .vram_rdata(vram_rdata),
        .vram_re(vram_re), .vram_we(vram_we), .vram_addr(vram_addr),
        .vram_wdata(vram_wdata), .cram_we(cram_we), .cram_addr(cram_addr),
        .cram_wdata(cram_wdata), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_val(reg_val), .rd_buf(rd_buf)
    );

    vdp_line_timer #(
        .ACTIVE_LINES(ACTIVE_LINES), .TOTAL_LINES(TOTAL_LINES),
        .CNT_W(8), .LINE_W(LINE_W)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .flag_clr(stat_rd),
        .reload(reload_q), .line_num(scan_line),
        .frame_flag(frame_flag), .line_flag(line_flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  reload_q <= 8'hFF;
        else if (reg_we && reg_idx == LINE_REG_L)    reload_q <= reg_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (cpu_sel && !cpu_wr) begin
            unique case (cpu_port)
                PORT_DATA: rdata_q <= rd_buf;
                PORT_CTRL: rdata_q <= {frame_flag, line_flag, 6'b0};
                PORT_VCNT: rdata_q <= scan_line[7:0];
                default:   ;
            endcase
        end
    end

    assign cpu_rdata = rdata_q;
    assign irq       = frame_flag | line_flag;

    AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !line_tick) |=> !irq); // R9

    AST_STATUS_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> (cpu_rdata[7] == $past(frame_flag) && cpu_rdata[5:0] == 6'b0)); // R9

endmodule

// File: tb/vdp_cpu_port_bench.sv
module vdp_cpu_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_sel = 1'b0, cpu_wr = 1'b0;
    logic [1:0]  cpu_port = 2'd0;
    logic [7:0]  cpu_wdata = 8'h00;
    logic [7:0]  cpu_rdata;
    logic        irq, line_tick = 1'b0;
    logic [8:0]  scan_line;
    logic        vram_re, vram_we, cram_we, reg_we;
    logic [13:0] vram_addr;
    logic [7:0]  vram_wdata, vram_rdata, cram_wdata, reg_val;
    logic [4:0]  cram_addr;
    logic [3:0]  reg_idx;

    always #10 clk = ~clk;

    vdp_cpu_port u_vdp_cpu_port (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
        .cpu_port(cpu_port), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .irq(irq), .line_tick(line_tick), .scan_line(scan_line),
        .vram_re(vram_re), .vram_we(vram_we), .vram_addr(vram_addr),
        .vram_wdata(vram_wdata), .vram_rdata(vram_rdata),
        .cram_we(cram_we), .cram_addr(cram_addr), .cram_wdata(cram_wdata),
        .reg_we(reg_we), .reg_idx(reg_idx), .reg_val(reg_val)
    );

    // external video RAM
    logic [7:0] hw_mem [256];
    logic [7:0] hw_q = 8'h00;
    initial for (int i = 0; i < 256; i++) hw_mem[i] = 8'h00;
    always @(posedge clk) begin
        if (vram_we) hw_mem[vram_addr[7:0]] <= vram_wdata;
        if (vram_re) hw_q <= hw_mem[vram_addr[7:0]];
    end
    assign vram_rdata = hw_q;

    int errors = 0, checks = 0;
    bit go = 0;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    byte unsigned mmem [256];
    int  m_tog, m_lo, m_code, m_addr, m_buf, cap_cnt, cap_val;
    int  m_line, m_cnt, m_reload, m_ff, m_lf;
    int  e_rdata, e_irq, e_vre, e_raddr, e_vwe, e_vaddr, e_vdata;
    int  e_cwe, e_caddr, e_cdata, e_rwe, e_ridx, e_rval;
    string m_rtag = "R1";
    initial for (int i = 0; i < 256; i++) mmem[i] = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tog = 0; m_lo = 0; m_code = 0; m_addr = 0; m_buf = 0; cap_cnt = 0; cap_val = 0;
            m_line = 0; m_cnt = 255; m_reload = 255; m_ff = 0; m_lf = 0;
            e_rdata = 0; e_irq = 0; e_vre = 0; e_raddr = 0; e_vwe = 0; e_vaddr = 0; e_vdata = 0;
            e_cwe = 0; e_caddr = 0; e_cdata = 0; e_rwe = 0; e_ridx = 0; e_rval = 0;
        end else begin
            int stat;
            e_vre = 0; e_vwe = 0; e_cwe = 0; e_rwe = 0;
            if (cap_cnt > 0) begin
                cap_cnt--;
                if (cap_cnt == 0) m_buf = cap_val;
            end
            stat = m_ff * 128 + m_lf * 64;
            if (cpu_sel) begin
                if (cpu_wr && cpu_port == 0) begin
                    m_tog = 0;
                    if (m_code == 3) begin
                        e_cwe = 1; e_caddr = m_addr % 32; e_cdata = cpu_wdata;
                    end else begin
                        e_vwe = 1; e_vaddr = m_addr; e_vdata = cpu_wdata;
                        mmem[m_addr % 256] = cpu_wdata;
                    end
                    m_addr = (m_addr + 1) % 16384;
                end else if (cpu_wr && cpu_port == 1) begin
                    if (m_tog == 0) begin
                        m_lo = cpu_wdata; m_tog = 1;
                    end else begin
                        m_tog = 0;
                        m_code = cpu_wdata / 64;
                        m_addr = (cpu_wdata % 64) * 256 + m_lo;
                        if (m_code == 0) begin
                            e_vre = 1; e_raddr = m_addr; cap_val = mmem[m_addr % 256]; cap_cnt = 2;
                            m_addr = (m_addr + 1) % 16384;
                        end else if (m_code == 2) begin
                            e_rwe = 1; e_ridx = cpu_wdata % 16; e_rval = m_lo;
                            if (e_ridx == 10) m_reload = m_lo;
                        end
                    end
                end else if (!cpu_wr && cpu_port == 0) begin
                    e_rdata = m_buf; m_rtag = "R4"; m_tog = 0;
                    e_vre = 1; e_raddr = m_addr; cap_val = mmem[m_addr % 256]; cap_cnt = 2;
                    m_addr = (m_addr + 1) % 16384;
                end else if (!cpu_wr && cpu_port == 1) begin
                    e_rdata = stat; m_rtag = "R9"; m_tog = 0; m_ff = 0; m_lf = 0;
                end else if (!cpu_wr && cpu_port == 2) begin
                    e_rdata = m_line % 256; m_rtag = "R11";
                end
            end
            if (line_tick) begin
                if (m_line < 192) begin
                    if (m_cnt == 0) begin m_lf = 1; m_cnt = m_reload; end
                    else m_cnt--;
                end else m_cnt = m_reload;
                if (m_line == 191) m_ff = 1;
                m_line = (m_line + 1) % 262;
            end
            e_irq = (m_ff | m_lf);
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) if (go) begin
        check(m_rtag, cpu_rdata, e_rdata);
        check(m_lf ? "R10" : "R8", irq, e_irq);
        check("R11", scan_line, m_line);
        check("R4", vram_re, e_vre);
        if (e_vre) check("R4", vram_addr, e_raddr);
        check("R3", vram_we, e_vwe);
        if (e_vwe) begin check("R3", vram_addr, e_vaddr); check("R3", vram_wdata, e_vdata); end
        check("R6", cram_we, e_cwe);
        if (e_cwe) begin check("R6", cram_addr, e_caddr); check("R6", cram_wdata, e_cdata); end
        check("R5", reg_we, e_rwe);
        if (e_rwe) begin check("R5", reg_idx, e_ridx); check("R5", reg_val, e_rval); end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // leaves in the cycle where the resulting strobe is visible
    task automatic acc(input bit wr, input int port, input int data);
        cpu_sel = 1; cpu_wr = wr; cpu_port = 2'(port); cpu_wdata = 8'(data);
        @(negedge clk);
        cpu_sel = 0; cpu_wr = 0; cpu_wdata = 8'h00;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            line_tick = 1; @(negedge clk);
            line_tick = 0; idle(3);
        end
    endtask

    bit done = 0;
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle(3);
        // R1 reset state
        check("R1", cpu_rdata, 0); check("R1", irq, 0); check("R1", scan_line, 0);
        check("R1", {vram_re, vram_we, cram_we, reg_we}, 0);
        rst_n = 1; idle(2); go = 1;

        // R2 first byte gives no strobe; R3 VRAM writes with auto-increment
        acc(1, 1, 8'h10);
        check("R2", {vram_re, vram_we, cram_we, reg_we}, 0); idle(4);
        acc(1, 1, 8'h40); idle(4);
        acc(1, 0, 8'hA1); idle(4);
        acc(1, 0, 8'hA2); idle(4);
        acc(1, 0, 8'hA3); idle(4);

        // R4 read setup prefetches, reads return buffer
        acc(1, 1, 8'h10); idle(4);
        acc(1, 1, 8'h00);
        check("R2", vram_re, 1); idle(4);
        acc(0, 0, 0); idle(1); check("R4", cpu_rdata, 8'hA1); idle(3);
        acc(0, 0, 0); idle(1); check("R4", cpu_rdata, 8'hA2); idle(3);
        acc(0, 0, 0); idle(1); check("R4", cpu_rdata, 8'hA3); idle(3);

        // R5 register write, reload value 5 into register 10
        acc(1, 1, 8'h05); idle(4);
        acc(1, 1, 8'h8A);
        check("R5", reg_idx, 10); idle(4);

        // R6 color RAM writes
        acc(1, 1, 8'h23); idle(4);
        acc(1, 1, 8'hC0); idle(4);
        acc(1, 0, 8'h3F);
        check("R6", cram_addr, 8'h03); idle(4);
        acc(1, 0, 8'h15); idle(4);

        // R7 stray first byte cleared by status read, then by data read
        acc(1, 1, 8'h77); idle(4);
        acc(0, 1, 0); idle(4);
        acc(1, 1, 8'h11); idle(4);
        acc(1, 1, 8'h00);
        check("R7", vram_addr, 14'h0011); idle(4);
        acc(1, 1, 8'h66); idle(4);
        acc(0, 0, 0); idle(4);
        acc(1, 1, 8'h12); idle(4);
        acc(1, 1, 8'h40); idle(4);
        acc(1, 0, 8'h5A);
        check("R7", vram_addr, 14'h0012); idle(4);

        // R8 R10 R11 scan timing across a frame boundary
        ticks(100);
        acc(0, 2, 0); idle(1); check("R11", cpu_rdata, 100); idle(3);
        ticks(95);
        check("R8", irq, 1);
        acc(0, 1, 0); idle(1); check("R9", cpu_rdata, 8'h80); check("R9", irq, 0); idle(3);
        ticks(67 + 6);
        check("R10", irq, 1);
        acc(0, 1, 0); idle(1); check("R9", cpu_rdata, 8'h40); idle(3);
        ticks(6);
        check("R10", irq, 1);
        acc(0, 2, 0); idle(1); check("R11", cpu_rdata, 12); idle(3);
        acc(0, 1, 0); idle(4);

        go = 0; done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule